// File: doc/BRIEF.md
# Valley-Skipping Switch-On Controller

This block decides when the main switch of a quasi-resonant flyback converter turns on and when it turns off. After every turn-off the drain rings, and each ringing valley shows up as a zero-crossing pulse. The block counts those pulses and turns the switch on only once a load-dependent number of valleys has gone by. At light load the off-time is therefore longer, so the switching frequency drops as the load falls.

The number of valleys to wait for is a saturating value. It is re-evaluated at the end of each fixed observation window, using three feedback comparator flags. A ringing suppression window and a maximum off-time limit the turn-on. A blanked current-sense trip and a maximum on-time limit the turn-off. All times are counts of the block clock, set by parameters.

The valley target is also brought out as an output, because light-load logic elsewhere decides things based on it reaching its top value.

Top module: `qr_valley_ctrl`

## Requirements
- R1: `skip_target` is an unsigned binary value that is 1 during and after reset and always stays between 1 and 7. A step up at 7 or a step down at 1 leaves it unchanged.
- R2: At the end of an observation window of `WIN_CYC` cycles, `skip_target` rises by one if `fb_above_lo` was low in every cycle of that window.
- R3: At the end of a window, `skip_target` is unchanged if `fb_above_lo` was high in at least one cycle of the window and `fb_above_hi` was low in every cycle.
- R4: At the end of a window, `skip_target` falls by one if `fb_above_hi` was high in at least one cycle of the window.
- R5: A cycle with `fb_above_rst` high sets `skip_target` to 1 at the next clock edge. The observation window restarts at that edge, so the next window decision comes `WIN_CYC` cycles later.
- R6: The internal valley tally counts `zc_edge` cycles while the gate is low and saturates at 7. It clears when the gate turns on. `zc_edge` is ignored while the gate is high.
- R7: The gate stays low for at least `RS_SHORT_CYC` cycles when `zc_level_hi` is high, and at least `RS_LONG_CYC` cycles when it is low. The level is evaluated in every off cycle.
- R8: Once suppression is over, the gate turns on at the first clock edge at which the tally (counting the pulses of earlier cycles) is greater than or equal to `skip_target`.
- R9: After `OFF_MAX_CYC` low cycles, the gate turns on regardless of the tally and of `zc_level_hi`. This also applies to the first turn-on after reset.
- R10: `cs_trip` turns the gate off at the next edge, except during the first `LEB_CYC` high cycles, when it is ignored. A trip present from the first high cycle gives a high time of `LEB_CYC`+1 cycles.
- R11: The gate turns off after `ON_MAX_CYC` high cycles when no trip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing parameters count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_above_lo | input | 1 | Feedback above the lower valley threshold |
| fb_above_hi | input | 1 | Feedback above the upper valley threshold |
| fb_above_rst | input | 1 | Feedback above the fast-recovery threshold |
| zc_edge | input | 1 | One-cycle pulse per detected falling zero crossing |
| zc_level_hi | input | 1 | Zero-crossing level is above the suppression threshold |
| cs_trip | input | 1 | Current-sense comparator has tripped |
| gate_drv | output | 1 | Main switch gate drive, high means on |
| skip_target | output | 3 | Number of valleys to wait for before turn-on (1 to 7) |

## Verification
The bench pushes the valley target against both of its limits. A counter that wraps would read 0 after an up-step at 7, or 7 after a down-step at 1. It sends a fast-recovery pulse in the middle of a window. A design that did not restart the window would then move the target a few cycles too early.

It sends nine crossings at a target of 7. A tally that wrapped would then miss its turn-on and run out to the maximum off-time. It also sends crossings during the on-time and right before a turn-on. A design that counted the first, or did not clear on turn-on, would turn on early in the next off-time.

Trips inside the blanking window check that the blanking applies. A design that ignored it would cut the on-time short.

// File: rtl/qr_valley_pkg.sv
package qr_valley_pkg;

  localparam int VAL_W = 3;
  localparam logic [VAL_W-1:0] VAL_MIN = 3'd1;
  localparam logic [VAL_W-1:0] VAL_MAX = 3'd7;

  typedef logic [VAL_W-1:0] val_t;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2
  } win_act_e;

  // Window verdict from the sticky comparator history.
  function automatic win_act_e win_decide(input logic saw_lo, input logic saw_hi);
    if (!saw_lo)      return ACT_UP;
    else if (!saw_hi) return ACT_HOLD;
    else              return ACT_DOWN;
  endfunction

  // Saturating move of the valley target.
  function automatic val_t tgt_step(input val_t v, input win_act_e a);
    case (a)
      ACT_UP:   return (v == VAL_MAX) ? v : v + 3'd1;
      ACT_DOWN: return (v == VAL_MIN) ? v : v - 3'd1;
      default:  return v;
    endcase
  endfunction

  // Saturating valley tally increment.
  function automatic val_t tally_inc(input val_t c);
    return (c == VAL_MAX) ? c : c + 3'd1;
  endfunction

endpackage

// File: rtl/qr_skip_target.sv
module qr_skip_target
  import qr_valley_pkg::*;
#(
  parameter int WIN_CYC = 2400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_lo,
  input  logic fb_hi,
  input  logic fb_rst,
  output val_t target
);

  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);

  logic [WW-1:0] win_cnt;
  logic          saw_lo, saw_hi;
  logic          saw_lo_n, saw_hi_n;
  logic          win_last;

  assign saw_lo_n = saw_lo | fb_lo;
  assign saw_hi_n = saw_hi | fb_hi;
  assign win_last = (win_cnt == WIN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target  <= VAL_MIN;
      win_cnt <= '0;
      saw_lo  <= 1'b0;
      saw_hi  <= 1'b0;
    end else if (fb_rst) begin
      target  <= VAL_MIN;
      win_cnt <= '0;
      saw_lo  <= 1'b0;
      saw_hi  <= 1'b0;
    end else if (win_last) begin
      target  <= tgt_step(target, win_decide(saw_lo_n, saw_hi_n));
      win_cnt <= '0;
      saw_lo  <= 1'b0;
      saw_hi  <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      saw_lo  <= saw_lo_n;
      saw_hi  <= saw_hi_n;
    end
  end

endmodule

// File: rtl/qr_zc_tally.sv
module qr_zc_tally
  import qr_valley_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic turn_on,
  input  logic zc_edge,
  output val_t tally
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tally <= '0;
    else if (turn_on)            tally <= '0;
    else if (!gate && zc_edge)   tally <= tally_inc(tally);
  end

endmodule

// File: rtl/qr_gate_seq.sv
module qr_gate_seq
  import qr_valley_pkg::*;
#(
  parameter int LEB_CYC      = 17,
  parameter int ON_MAX_CYC   = 1500,
  parameter int RS_SHORT_CYC = 125,
  parameter int RS_LONG_CYC  = 1250,
  parameter int OFF_MAX_CYC  = 2100,
  localparam int OW = $clog2(OFF_MAX_CYC + 1),
  localparam int NW = $clog2(ON_MAX_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zc_level_hi,
  input  logic          cs_trip,
  input  val_t          tally,
  input  val_t          target,
  output logic          gate,
  output logic          turn_on,
  output logic [OW-1:0] off_len,
  output logic [NW-1:0] on_len
);

  localparam logic [OW-1:0] OFF_MAX_V = OW'(OFF_MAX_CYC);
  localparam logic [OW-1:0] RS_S_V    = OW'(RS_SHORT_CYC);
  localparam logic [OW-1:0] RS_L_V    = OW'(RS_LONG_CYC);
  localparam logic [NW-1:0] ON_MAX_V  = NW'(ON_MAX_CYC);
  localparam logic [NW-1:0] LEB_V     = NW'(LEB_CYC);

  logic supp_over, off_expired, valley_ok;
  logic trip_seen, on_expired, turn_off;

  assign supp_over   = off_len >= (zc_level_hi ? RS_S_V : RS_L_V);
  assign off_expired = off_len >= OFF_MAX_V;
  assign valley_ok   = supp_over && (tally >= target);
  assign turn_on     = !gate && (off_expired || valley_ok);

  assign trip_seen   = cs_trip && (on_len > LEB_V);
  assign on_expired  = on_len >= ON_MAX_V;
  assign turn_off    = gate && (trip_seen || on_expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate    <= 1'b0;
      off_len <= OW'(1);
      on_len  <= '0;
    end else if (turn_on) begin
      gate    <= 1'b1;
      off_len <= '0;
      on_len  <= NW'(1);
    end else if (turn_off) begin
      gate    <= 1'b0;
      off_len <= OW'(1);
      on_len  <= '0;
    end else if (gate) begin
      if (!on_expired) on_len <= on_len + 1'b1;
    end else begin
      if (!off_expired) off_len <= off_len + 1'b1;
    end
  end

endmodule

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl
  import qr_valley_pkg::*;
#(
  parameter int WIN_CYC      = 2400000,
  parameter int LEB_CYC      = 17,
  parameter int ON_MAX_CYC   = 1500,
  parameter int RS_SHORT_CYC = 125,
  parameter int RS_LONG_CYC  = 1250,
  parameter int OFF_MAX_CYC  = 2100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_above_lo,
  input  logic       fb_above_hi,
  input  logic       fb_above_rst,
  input  logic       zc_edge,
  input  logic       zc_level_hi,
  input  logic       cs_trip,
  output logic       gate_drv,
  output logic [2:0] skip_target
);

  localparam int OW = $clog2(OFF_MAX_CYC + 1);
  localparam int NW = $clog2(ON_MAX_CYC + 1);

  // Named internal events, also watched by the bound checker.
  val_t          zc_cnt;
  logic          turn_on;
  logic [OW-1:0] off_len;
  logic [NW-1:0] on_len;

  qr_skip_target #(.WIN_CYC(WIN_CYC)) u_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .fb_lo  (fb_above_lo),
    .fb_hi  (fb_above_hi),
    .fb_rst (fb_above_rst),
    .target (skip_target)
  );

  qr_zc_tally u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate    (gate_drv),
    .turn_on (turn_on),
    .zc_edge (zc_edge),
    .tally   (zc_cnt)
  );

  qr_gate_seq #(
    .LEB_CYC      (LEB_CYC),
    .ON_MAX_CYC   (ON_MAX_CYC),
    .RS_SHORT_CYC (RS_SHORT_CYC),
    .RS_LONG_CYC  (RS_LONG_CYC),
    .OFF_MAX_CYC  (OFF_MAX_CYC)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .zc_level_hi (zc_level_hi),
    .cs_trip     (cs_trip),
    .tally       (zc_cnt),
    .target      (skip_target),
    .gate        (gate_drv),
    .turn_on     (turn_on),
    .off_len     (off_len),
    .on_len      (on_len)
  );

endmodule

// File: rtl/qr_valley_ctrl_chk.sv
module qr_valley_ctrl_chk #(
  parameter int LEB_CYC      = 17,
  parameter int ON_MAX_CYC   = 1500,
  parameter int RS_SHORT_CYC = 125,
  parameter int OFF_MAX_CYC  = 2100,
  localparam int OW = $clog2(OFF_MAX_CYC + 1),
  localparam int NW = $clog2(ON_MAX_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_drv,
  input logic          fb_above_rst,
  input logic [2:0]    skip_target,
  input logic [2:0]    zc_cnt,
  input logic [OW-1:0] off_len,
  input logic [NW-1:0] on_len
);

  localparam logic [OW-1:0] OFF_MAX_V = OW'(OFF_MAX_CYC);
  localparam logic [OW-1:0] RS_S_V    = OW'(RS_SHORT_CYC);
  localparam logic [NW-1:0] ON_MAX_V  = NW'(ON_MAX_CYC);
  localparam logic [NW-1:0] LEB_V     = NW'(LEB_CYC);

  // R1
  tgt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_target >= 3'd1) && (skip_target <= 3'd7));

  // R5
  fast_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_above_rst |=> (skip_target == 3'd1));

  // R6
  tally_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_drv |-> (zc_cnt == 3'd0));

  // R7
  suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_drv) |-> ($past(off_len) >= RS_S_V));

  // R8
  valley_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_drv) && ($past(off_len) < OFF_MAX_V)) |->
      ($past(zc_cnt) >= $past(skip_target)));

  // R9
  off_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_drv && (off_len >= OFF_MAX_V)) |=> gate_drv);

  // R10
  blanking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_drv && (on_len <= LEB_V)) |=> gate_drv);

  // R11
  on_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_drv && (on_len >= ON_MAX_V)) |=> !gate_drv);

endmodule

bind qr_valley_ctrl qr_valley_ctrl_chk #(
  .LEB_CYC      (LEB_CYC),
  .ON_MAX_CYC   (ON_MAX_CYC),
  .RS_SHORT_CYC (RS_SHORT_CYC),
  .OFF_MAX_CYC  (OFF_MAX_CYC)
) u_chk (.*);

// File: tb/test_qr_valley_ctrl.sv
module test_qr_valley_ctrl;

  localparam int W    = 16;
  localparam int LEB  = 3;
  localparam int ONM  = 12;
  localparam int RSS  = 4;
  localparam int RSL  = 10;
  localparam int OFFM = 30;

  // {window pattern[1:0], expected target[2:0]}; 0 = no flag, 1 = low flag pulse, 2 = both flags pulse
  localparam logic [4:0] VEC [16] = '{
    {2'd0, 3'd2}, {2'd0, 3'd3}, {2'd0, 3'd4}, {2'd0, 3'd5},
    {2'd0, 3'd6}, {2'd0, 3'd7}, {2'd0, 3'd7}, {2'd1, 3'd7},
    {2'd2, 3'd6}, {2'd1, 3'd6}, {2'd2, 3'd5}, {2'd2, 3'd4},
    {2'd2, 3'd3}, {2'd2, 3'd2}, {2'd2, 3'd1}, {2'd2, 3'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_above_lo = 1'b1, fb_above_hi = 1'b0, fb_above_rst = 1'b0;
  logic zc_edge = 1'b0, zc_level_hi = 1'b0, cs_trip = 1'b0;
  logic gate_drv;
  logic [2:0] skip_target;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qr_valley_ctrl #(
    .WIN_CYC(W), .LEB_CYC(LEB), .ON_MAX_CYC(ONM),
    .RS_SHORT_CYC(RSS), .RS_LONG_CYC(RSL), .OFF_MAX_CYC(OFFM)
  ) i_qr_valley_ctrl (
    .clk(clk), .rst_n(rst_n), .fb_above_lo(fb_above_lo), .fb_above_hi(fb_above_hi),
    .fb_above_rst(fb_above_rst), .zc_edge(zc_edge), .zc_level_hi(zc_level_hi),
    .cs_trip(cs_trip), .gate_drv(gate_drv), .skip_target(skip_target)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Counts negedges until gate_drv shows val.
  task automatic wait_level(input logic val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (gate_drv !== val && n < 500);
  endtask

  // Called at the negedge the gate is first seen high; ends at the first low negedge.
  task automatic trip_off(output int n);
    cs_trip = 1'b1;
    wait_level(1'b0, n);
    cs_trip = 1'b0;
  endtask

  // Called at the first low negedge; mask bit m drives a crossing in off cycle m+1.
  task automatic run_off(input logic hi, input logic [31:0] mask, output int n);
    zc_level_hi = hi;
    n = 0;
    do begin
      zc_edge = (n < 32) ? mask[n] : 1'b0;
      @(negedge clk);
      n++;
    end while (gate_drv !== 1'b1 && n < 500);
    zc_edge = 1'b0;
  endtask

  task automatic set_tgt(input int steps);
    fb_above_rst = 1'b1;
    fb_above_lo = 1'b0;
    @(negedge clk);
    fb_above_rst = 1'b0;
    repeat (steps * W) @(negedge clk);
    fb_above_lo = 1'b1;
  endtask

  task automatic sync_rise();
    int n;
    wait_level(1'b0, n);
    wait_level(1'b1, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 100000);
    summary();
  end

  initial begin
    int n;
    int m;
    repeat (3) @(negedge clk);
    chk("R1 reset target", int'(skip_target), 1);
    chk("R9 reset gate low", int'(gate_drv), 0);
    rst_n = 1'b1;

    wait_level(1'b1, n);
    chk("R9 first turn-on at off max", n, OFFM);
    wait_level(1'b0, n);
    chk("R11 on max", n, ONM);
    run_off(1'b1, 32'h1, n);
    chk("R7 R8 short suppression with one valley", n, RSS);
    trip_off(n);
    chk("R10 trip after blanking", n, LEB + 1);
    run_off(1'b0, 32'h1, n);
    chk("R7 long suppression", n, RSL);

    cs_trip = 1'b1;
    repeat (LEB) @(negedge clk);
    cs_trip = 1'b0;
    wait_level(1'b0, n);
    chk("R10 trip ignored in blanking", LEB + n, ONM);
    run_off(1'b1, 32'h0, n);
    chk("R9 no valley reaches off max", n, OFFM);
    chk("R3 target held", int'(skip_target), 1);

    set_tgt(2);
    chk("R2 target stepped to 3", int'(skip_target), 3);
    sync_rise();
    trip_off(n);
    run_off(1'b1, 32'h2A0, n);
    chk("R8 third valley turns on", n, 11);

    cs_trip = 1'b1;
    zc_edge = 1'b1;
    wait_level(1'b0, n);
    zc_edge = 1'b0;
    cs_trip = 1'b0;
    run_off(1'b1, 32'hA0, n);
    chk("R6 crossings during on ignored", n, OFFM);

    trip_off(n);
    run_off(1'b1, 32'h7, n);
    chk("R8 three early valleys", n, RSS);
    trip_off(n);
    run_off(1'b1, 32'hA0, n);
    chk("R6 tally cleared at turn-on", n, OFFM);

    set_tgt(6);
    chk("R1 target at 7", int'(skip_target), 7);
    sync_rise();
    trip_off(n);
    run_off(1'b0, 32'h1FF, n);
    chk("R6 tally saturates at 7", n, RSL);

    // Vector table: consecutive windows after a fast reset.
    fb_above_rst = 1'b1;
    fb_above_lo = 1'b0;
    @(negedge clk);
    fb_above_rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < W; j++) begin
        fb_above_lo = (VEC[i][4:3] != 2'd0) && (j == 5);
        fb_above_hi = (VEC[i][4:3] == 2'd2) && (j == 5);
        @(negedge clk);
      end
      chk($sformatf("R2 R3 R4 R1 window vector %0d", i), int'(skip_target), int'(VEC[i][2:0]));
    end
    fb_above_lo = 1'b0;
    fb_above_hi = 1'b0;

    repeat (W) @(negedge clk);
    chk("R2 step up before fast reset", int'(skip_target), 2);
    repeat (3) @(negedge clk);
    fb_above_rst = 1'b1;
    @(negedge clk);
    fb_above_rst = 1'b0;
    chk("R5 fast reset to 1", int'(skip_target), 1);
    m = W - 1;
    repeat (m) @(negedge clk);
    chk("R5 window restarted", int'(skip_target), 1);
    @(negedge clk);
    chk("R5 decision one window later", int'(skip_target), 2);

    summary();
  end

endmodule